// File: doc/BRIEF.md
# Six-Stage Pipelined Single-Precision Adder

This block adds two IEEE-754 single-precision numbers in a fixed six-stage pipeline. It takes one operand pair per clock when `in_valid_i` is high. The sum comes out exactly six clocks later with `out_valid_o`. A stream of n back-to-back pairs therefore finishes in 6 + (n-1) cycles. The stages run in this order:

1. Operand ordering by magnitude, which picks the smaller operand.
2. Right shift of the smaller significand to equalize the exponents.
3. Significand addition or subtraction.
4. Normalization.
5. Exception screening.
6. Round-to-nearest-even.

There is no subtract opcode: a caller subtracts by flipping the sign bit of one operand. There are no stalls and no back-pressure. The valid bit moves with the data, and reset empties the pipe.

The word layout is the standard one: sign in bit 31, biased exponent in bits 30:23, fraction in bits 22:0. Inputs whose exponent field is zero are taken as zero with their own sign. The block never produces a subnormal. Three flags accompany each result: overflow, underflow and invalid.

Top module: `fpadd_pipe6`

## Requirements
- R1: A pair accepted with `in_valid_i` high at clock edge k gives `out_valid_o` high with its result after edge k+6. Pairs may be presented on every cycle, and results leave in order, one per cycle.
- R2: For two normal operands the result is the exact sum rounded to nearest, with ties going to the even fraction.
- R3: When the operand signs differ, the smaller magnitude is subtracted from the larger, with full cancellation handled. An exact zero from opposite signs is +0 (0x00000000), and -0 plus -0 gives -0 (0x80000000).
- R4: When the exponent difference is 27 or more, the smaller operand affects the result only through the sticky bit.
- R5: An input with exponent field 0 acts as a zero of its own sign. No output has exponent field 0 with a non-zero fraction.
- R6: When rounding carries out of the significand, the exponent goes up by one and the fraction becomes zero.
- R7: If the exponent reaches 255 before or after rounding, the result is an infinity of the result sign (exponent 255, fraction 0) and `overflow_o` is raised.
- R8: If the normalized exponent is 0 or below before rounding, the result is a zero of the result sign and `underflow_o` is raised.
- R9: A NaN on either input (exponent 255 with a non-zero fraction), or two infinities of opposite sign, gives the quiet NaN 0x7FC00000 and raises `invalid_o`.
- R10: An infinity added to a finite value, or to an infinity of the same sign, passes through unchanged, with no flag raised.
- R11: While `rst_ni` is low, and from its release until the first accepted pair has travelled six stages, `out_valid_o` is low. Pairs in flight when reset is asserted never appear.
- R12: At most one flag is set with any result. All flags are low for results that are exact or correctly rounded normals or zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operand pair is present this cycle |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| out_valid_o | output | 1 | Result is present this cycle |
| sum_o | output | 32 | Rounded sum |
| overflow_o | output | 1 | Result overflowed to infinity |
| underflow_o | output | 1 | Result flushed to zero |
| invalid_o | output | 1 | Invalid operation, NaN returned |

## Verification
The assertions check four things on every cycle:

- The six-cycle valid latency and the quiet output after reset.
- That the normalization stage always leaves the hidden bit set.
- That overflow, underflow and invalid results carry their fixed encodings, and that at most one flag is raised.
- That no subnormal pattern ever leaves the block.

Whether a sum is rounded correctly can only be shown by the bench scenarios. These compare each result with an exact integer model, covering:

- ties to even and rounding carries;
- cancellation and sticky-only alignment;
- overflow that appears only after rounding;
- a reset that lands while pairs are in flight.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;
  typedef enum logic [1:0] {KIND_FIN, KIND_ZERO, KIND_INF, KIND_NAN} kind_e;
  localparam int unsigned NUM_STAGES = 6;
endpackage

// File: rtl/fpadd_align.sv
module fpadd_align #(
  parameter int unsigned SIG_W  = 24,
  parameter int unsigned DIST_W = 8,
  localparam int unsigned EXT_W = SIG_W + 3
) (
  input  logic [SIG_W-1:0]  sig_i,
  input  logic [DIST_W-1:0] dist_i,
  output logic [EXT_W-1:0]  ext_o  // {sig, guard, round, sticky}
);
  localparam int unsigned WIDE_W = SIG_W + EXT_W - 1;
  localparam logic [DIST_W-1:0] SAT = DIST_W'(EXT_W);

  logic [WIDE_W-1:0] wide;

  always_comb begin
    wide = {sig_i, {(EXT_W-1){1'b0}}} >> dist_i;
    if (dist_i >= SAT) ext_o = {{(EXT_W-1){1'b0}}, |sig_i};
    else               ext_o = {wide[WIDE_W-1 -: EXT_W-1], |wide[SIG_W-1:0]};
  end
endmodule

// File: rtl/fpadd_lzc.sv
module fpadd_lzc #(
  parameter int unsigned W = 27,
  localparam int unsigned CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec_i,
  output logic [CW-1:0] cnt_o
);
  logic hit;
  always_comb begin
    cnt_o = '0;
    hit   = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      if (!hit) begin
        if (vec_i[i]) hit = 1'b1;
        else          cnt_o = cnt_o + CW'(1);
      end
    end
  end
endmodule

// File: rtl/fpadd_round.sv
module fpadd_round #(
  parameter int unsigned EXP_W  = 8,
  parameter int unsigned FRAC_W = 23,
  localparam int unsigned SIG_W = FRAC_W + 1,
  localparam int unsigned EXT_W = SIG_W + 3
) (
  input  logic [EXT_W-1:0]  m_i,
  input  logic [EXP_W-1:0]  e_i,
  output logic [FRAC_W-1:0] frac_o,
  output logic [EXP_W-1:0]  e_o
);
  logic             up, carry;
  logic [SIG_W-1:0] sig;

  always_comb begin
    up = m_i[2] & (m_i[1] | m_i[0] | m_i[3]);
    {carry, sig} = {1'b0, m_i[EXT_W-1:3]} + (SIG_W+1)'(up);
    frac_o = carry ? sig[FRAC_W:1] : sig[FRAC_W-1:0];
    e_o    = e_i + EXP_W'(carry);
  end
endmodule

// File: rtl/fpadd_pipe6.sv
module fpadd_pipe6
  import fpadd_pkg::*;
#(
  parameter int unsigned EXP_W  = 8,
  parameter int unsigned FRAC_W = 23,
  localparam int unsigned W     = 1 + EXP_W + FRAC_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         in_valid_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         out_valid_o,
  output logic [W-1:0] sum_o,
  output logic         overflow_o,
  output logic         underflow_o,
  output logic         invalid_o
);
  localparam int unsigned SIG_W = FRAC_W + 1;
  localparam int unsigned EXT_W = SIG_W + 3;
  localparam int unsigned SUM_W = EXT_W + 1;
  localparam int unsigned NE_W  = EXP_W + 2;
  localparam int unsigned LZ_W  = $clog2(EXT_W + 1);
  localparam int          EXP_ONES = 2**EXP_W - 1;
  localparam logic signed [NE_W-1:0] E_TOP = NE_W'(EXP_ONES);
  localparam logic [W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  logic [NUM_STAGES-1:0] vld_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) vld_q <= '0;
    else         vld_q <= {vld_q[NUM_STAGES-2:0], in_valid_i};

  // ---- stage 1: classify, order by magnitude
  logic              a_s, b_s;
  logic [EXP_W-1:0]  a_e, b_e, a_ee, b_ee;
  logic [FRAC_W-1:0] a_f, b_f;
  logic              a_nan, b_nan, a_inf, b_inf, a_big;
  logic [SIG_W-1:0]  a_sig, b_sig;
  kind_e             k1;
  logic              sgn1;

  assign {a_s, a_e, a_f} = a_i;
  assign {b_s, b_e, b_f} = b_i;
  assign a_ee  = (a_e == '0) ? '0 : a_e;
  assign b_ee  = (b_e == '0) ? '0 : b_e;
  assign a_sig = (a_e == '0) ? '0 : {1'b1, a_f};
  assign b_sig = (b_e == '0) ? '0 : {1'b1, b_f};
  assign a_nan = (a_e == '1) &  (|a_f);
  assign b_nan = (b_e == '1) &  (|b_f);
  assign a_inf = (a_e == '1) & ~(|a_f);
  assign b_inf = (b_e == '1) & ~(|b_f);
  assign a_big = {a_ee, a_sig} >= {b_ee, b_sig};

  always_comb begin
    k1   = KIND_FIN;
    sgn1 = a_big ? a_s : b_s;
    if (a_nan | b_nan | (a_inf & b_inf & (a_s ^ b_s))) k1 = KIND_NAN;
    else if (a_inf | b_inf) begin
      k1   = KIND_INF;
      sgn1 = a_inf ? a_s : b_s;
    end
  end

  logic s1_sign, s1_sub;
  logic [EXP_W-1:0] s1_exp, s1_diff;
  logic [SIG_W-1:0] s1_bsig, s1_ssig;
  kind_e s1_kind;

  always_ff @(posedge clk_i) begin
    s1_sign <= sgn1;
    s1_sub  <= a_s ^ b_s;
    s1_kind <= k1;
    s1_exp  <= a_big ? a_ee : b_ee;
    s1_diff <= a_big ? a_ee - b_ee : b_ee - a_ee;
    s1_bsig <= a_big ? a_sig : b_sig;
    s1_ssig <= a_big ? b_sig : a_sig;
  end

  // ---- stage 2: align smaller significand
  logic [EXT_W-1:0] small_ext;

  fpadd_align #(.SIG_W(SIG_W), .DIST_W(EXP_W)) u_align (
    .sig_i (s1_ssig),
    .dist_i(s1_diff),
    .ext_o (small_ext)
  );

  logic s2_sign, s2_sub;
  logic [EXP_W-1:0] s2_exp;
  logic [EXT_W-1:0] s2_big, s2_small;
  kind_e s2_kind;

  always_ff @(posedge clk_i) begin
    s2_sign  <= s1_sign;
    s2_sub   <= s1_sub;
    s2_kind  <= s1_kind;
    s2_exp   <= s1_exp;
    s2_big   <= {s1_bsig, 3'b000};
    s2_small <= small_ext;
  end

  // ---- stage 3: add / subtract magnitudes
  logic s3_sign, s3_sub;
  logic [EXP_W-1:0] s3_exp;
  logic [SUM_W-1:0] s3_sum;
  kind_e s3_kind;

  always_ff @(posedge clk_i) begin
    s3_sign <= s2_sign;
    s3_sub  <= s2_sub;
    s3_kind <= s2_kind;
    s3_exp  <= s2_exp;
    s3_sum  <= s2_sub ? {1'b0, s2_big} - {1'b0, s2_small}
                      : {1'b0, s2_big} + {1'b0, s2_small};
  end

  // ---- stage 4: normalize
  logic [LZ_W-1:0] lz;
  logic [EXT_W-1:0] n_m;
  logic signed [NE_W-1:0] n_e;
  logic n_zero;

  fpadd_lzc #(.W(EXT_W)) u_lzc (
    .vec_i(s3_sum[EXT_W-1:0]),
    .cnt_o(lz)
  );

  always_comb begin
    n_zero = (s3_sum == '0);
    if (s3_sum[SUM_W-1]) begin
      n_m = {s3_sum[SUM_W-1:2], |s3_sum[1:0]};
      n_e = NE_W'(s3_exp) + NE_W'(1);
    end else begin
      n_m = s3_sum[EXT_W-1:0] << lz;
      n_e = NE_W'(s3_exp) - NE_W'(lz);
    end
  end

  logic s4_sign, s4_zero;
  logic [EXT_W-1:0] s4_m;
  logic signed [NE_W-1:0] s4_e;
  kind_e s4_kind;

  always_ff @(posedge clk_i) begin
    s4_sign <= (n_zero && s3_sub) ? 1'b0 : s3_sign;
    s4_zero <= n_zero;
    s4_kind <= s3_kind;
    s4_m    <= n_m;
    s4_e    <= n_e;
  end

  // ---- stage 5: exception screening
  kind_e k5;
  logic  ovf5, unf5;

  always_comb begin
    k5   = s4_kind;
    ovf5 = 1'b0;
    unf5 = 1'b0;
    if (s4_kind == KIND_FIN) begin
      if (s4_zero) k5 = KIND_ZERO;
      else if (!s4_e[NE_W-1] && s4_e >= E_TOP) begin
        k5   = KIND_INF;
        ovf5 = 1'b1;
      end else if (s4_e[NE_W-1] || s4_e == '0) begin
        k5   = KIND_ZERO;
        unf5 = 1'b1;
      end
    end
  end

  logic s5_sign, s5_ovf, s5_unf;
  logic [EXT_W-1:0] s5_m;
  logic [EXP_W-1:0] s5_e;
  kind_e s5_kind;

  always_ff @(posedge clk_i) begin
    s5_sign <= s4_sign;
    s5_kind <= k5;
    s5_ovf  <= ovf5;
    s5_unf  <= unf5;
    s5_m    <= s4_m;
    s5_e    <= EXP_W'(s4_e);
  end

  // ---- stage 6: round and pack
  logic [FRAC_W-1:0] r_f;
  logic [EXP_W-1:0]  r_e;
  logic [W-1:0]      res6;
  logic              ovf6, unf6, inv6;

  fpadd_round #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_round (
    .m_i   (s5_m),
    .e_i   (s5_e),
    .frac_o(r_f),
    .e_o   (r_e)
  );

  always_comb begin
    ovf6 = 1'b0;
    unf6 = 1'b0;
    inv6 = 1'b0;
    unique case (s5_kind)
      KIND_NAN:  begin res6 = QNAN; inv6 = 1'b1; end
      KIND_INF:  begin res6 = {s5_sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}}; ovf6 = s5_ovf; end
      KIND_ZERO: begin res6 = {s5_sign, {(W-1){1'b0}}}; unf6 = s5_unf; end
      default: begin
        if (r_e == '1) begin
          res6 = {s5_sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
          ovf6 = 1'b1;
        end else res6 = {s5_sign, r_e, r_f};
      end
    endcase
  end

  always_ff @(posedge clk_i) begin
    sum_o       <= res6;
    overflow_o  <= ovf6;
    underflow_o <= unf6;
    invalid_o   <= inv6;
  end

  assign out_valid_o = vld_q[NUM_STAGES-1];

  // ---- assertions
  logic [2:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) age_q <= '0;
    else if (age_q != 3'(NUM_STAGES)) age_q <= age_q + 3'd1;

  AST_FIXED_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 3'(NUM_STAGES)) |-> (out_valid_o == $past(in_valid_i, NUM_STAGES))); // R1
  AST_QUIET_AFTER_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q < 3'(NUM_STAGES)) |-> !out_valid_o); // R11
  AST_HIDDEN_BIT_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_q[3] && s4_kind == KIND_FIN && !s4_zero) |-> s4_m[EXT_W-1]); // R2
  AST_NO_SUBNORMAL_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && sum_o[W-2 -: EXP_W] == '0) |-> (sum_o[FRAC_W-1:0] == '0)); // R5
  AST_OVF_IS_INF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && overflow_o) |-> (sum_o[W-2:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}})); // R7
  AST_UNF_IS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && underflow_o) |-> (sum_o[W-2:0] == '0)); // R8
  AST_INV_IS_QNAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && invalid_o) |-> (sum_o == QNAN)); // R9
  AST_ONE_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> ($countones({overflow_o, underflow_o, invalid_o}) <= 1)); // R12
endmodule

// File: tb/fpadd_pipe6_tb_top.sv
`timescale 1ns/1ps
module fpadd_pipe6_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic [31:0] a_i = '0, b_i = '0;
  logic        out_valid_o, overflow_o, underflow_o, invalid_o;
  logic [31:0] sum_o;

  fpadd_pipe6 dut_i (
    .clk_i, .rst_ni, .in_valid_i, .a_i, .b_i,
    .out_valid_o, .sum_o, .overflow_o, .underflow_o, .invalid_o
  );

  always #4 clk_i = ~clk_i;  // 125 MHz

  typedef struct {
    logic [31:0] res;
    logic        ovf, unf, inv;
    longint      due;
    string       tag;
  } exp_t;

  exp_t   sb[$];
  int     checks = 0, errors = 0;
  longint cyc = 0;
  bit     done = 0;

  always @(posedge clk_i) cyc <= cyc + 1;

  // exact integer reference: returns {res, ovf, unf, inv}
  function automatic logic [34:0] ref_add(input logic [31:0] a, input logic [31:0] b);
    logic sa = a[31], sb_ = b[31];
    int ea = int'(a[30:23]), eb = int'(b[30:23]);
    longint ma, mb, mh, ml, t, mag, keep, rem, half;
    int eh, el, d, base, p, e, sh;
    logic sgh, sgl, neg;
    if ((ea == 255 && a[22:0] != 0) || (eb == 255 && b[22:0] != 0)) return {32'h7FC00000, 3'b001};
    if (ea == 255 && eb == 255) return (sa != sb_) ? {32'h7FC00000, 3'b001} : {a, 3'b000};
    if (ea == 255) return {a, 3'b000};
    if (eb == 255) return {b, 3'b000};
    ma = (ea == 0) ? 0 : ((64'd1 << 23) | longint'(a[22:0]));
    mb = (eb == 0) ? 0 : ((64'd1 << 23) | longint'(b[22:0]));
    if (ma == 0 && mb == 0) return {(sa & sb_), 31'b0, 3'b000};
    if (ea >= eb) begin eh = ea; mh = ma; sgh = sa; el = eb; ml = mb; sgl = sb_; end
    else          begin eh = eb; mh = mb; sgh = sb_; el = ea; ml = ma; sgl = sa; end
    d = eh - el;
    if (d > 38) begin d = 38; ml = (ml != 0) ? 1 : 0; end
    base = eh - d;
    t = (sgh ? -(mh <<< d) : (mh <<< d)) + (sgl ? -ml : ml);
    if (t == 0) return {32'h0, 3'b000};
    neg = (t < 0);
    mag = neg ? -t : t;
    p = 0;
    for (int i = 0; i < 63; i++) if (mag[i]) p = i;
    e = base + p - 23;
    if (e <= 0) return {neg, 31'b0, 3'b010};
    if (p > 23) begin
      sh   = p - 23;
      keep = mag >> sh;
      rem  = mag & ((64'd1 << sh) - 1);
      half = 64'd1 << (sh - 1);
      if (rem > half || (rem == half && keep[0])) keep = keep + 1;
      if (keep == (64'd1 << 24)) begin keep = keep >> 1; e = e + 1; end
    end else keep = mag << (23 - p);
    if (e >= 255) return {neg, 8'hFF, 23'b0, 3'b100};
    return {neg, e[7:0], keep[22:0], 3'b000};
  endfunction

  task automatic drive(input logic [31:0] a, input logic [31:0] b, input string tag);
    exp_t x;
    logic [34:0] r;
    @(negedge clk_i);
    in_valid_i = 1'b1;
    a_i = a;
    b_i = b;
    r = ref_add(a, b);
    x.res = r[34:3]; x.ovf = r[2]; x.unf = r[1]; x.inv = r[0];
    x.due = cyc + 6;
    x.tag = tag;
    sb.push_back(x);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      in_valid_i = 1'b0;
    end
  endtask

  task automatic check_quiet(input string tag);
    @(negedge clk_i);
    in_valid_i = 1'b0;
    checks++;
    if (out_valid_o !== 1'b0) begin
      errors++;
      $display("FAIL %s out_valid actual=%b expected=0", tag, out_valid_o);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk_i) begin
    exp_t e;
    if (rst_ni && !done) begin
      if (out_valid_o) begin
        if (sb.size() == 0) begin
          checks++; errors++;
          $display("FAIL R1 unexpected result actual=%h expected=none", sum_o);
        end else begin
          e = sb.pop_front();
          checks++;
          if (e.due != cyc) begin
            errors++;
            $display("FAIL R1 latency actual=%0d expected=%0d", cyc - (e.due - 6), 6);
          end
          if (sum_o !== e.res || overflow_o !== e.ovf || underflow_o !== e.unf || invalid_o !== e.inv) begin
            errors++;
            $display("FAIL %s actual=%h ovf%b unf%b inv%b expected=%h ovf%b unf%b inv%b", e.tag,
                     sum_o, overflow_o, underflow_o, invalid_o, e.res, e.ovf, e.unf, e.inv);
          end
        end
      end else if (sb.size() > 0 && sb[0].due <= cyc) begin
        e = sb.pop_front();
        checks++; errors++;
        $display("FAIL R1 missing result actual=no-valid expected=%h", e.res);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    // R11: quiet during and after reset
    check_quiet("R11");
    check_quiet("R11");
    @(negedge clk_i) rst_ni = 1'b1;
    check_quiet("R11");

    // back-to-back directed stream (R1 timing checked per item)
    drive(32'h3F800000, 32'h3F800000, "R2 one+one");
    drive(32'h3FC00000, 32'h40100000, "R2 1.5+2.25");
    drive(32'h3F800000, 32'h33800000, "R2 tie to even down");
    drive(32'h3F800000, 32'h33C00000, "R2 above half");
    drive(32'h3F800001, 32'h33800000, "R2 tie to even up");
    drive(32'h3F800000, 32'hBF800000, "R3 exact cancel +0");
    drive(32'h80000000, 32'h80000000, "R3 -0 plus -0");
    drive(32'h3F800000, 32'hBF7FFFFF, "R3 deep cancel");
    drive(32'hC0400000, 32'h3F800000, "R3 neg larger");
    drive(32'h3F800000, 32'hB0800000, "R4 far sub");
    drive(32'h4B000000, 32'h2F000001, "R4 far add");
    drive(32'h3F800000, 32'h00000001, "R5 subnormal flush");
    drive(32'h00400000, 32'h80400000, "R5 two subnormals");
    drive(32'h80000001, 32'h80000000, "R5 neg subnormal");
    drive(32'h3FFFFFFF, 32'h33800000, "R6 round carry");
    drive(32'h7F7FFFFF, 32'h7F7FFFFF, "R7 overflow pre-round");
    drive(32'h7F7FFFFF, 32'h73000000, "R7 overflow by rounding");
    drive(32'hFF7FFFFF, 32'hFF7FFFFF, "R7 neg overflow");
    drive(32'h01000000, 32'h80C00000, "R8 underflow");
    drive(32'h81000000, 32'h00C00000, "R8 neg underflow");
    drive(32'h7F800001, 32'h3F800000, "R9 nan in");
    drive(32'h7F800000, 32'hFF800000, "R9 inf minus inf");
    drive(32'h3F800000, 32'hFFC00000, "R9 nan b");
    drive(32'h7F800000, 32'hC0000000, "R10 inf plus finite");
    drive(32'hFF800000, 32'hFF800000, "R10 same infs");
    drive(32'h3F800000, 32'hFF800000, "R10 finite plus -inf");
    idle(3);

    // R2/R3/R4/R12 random stream, back to back
    for (int n = 0; n < 400; n++) begin
      logic [31:0] x, y;
      int ea, eb;
      ea = 110 + int'($urandom_range(0, 30));
      eb = ea - int'($urandom_range(0, 45));
      if (eb < 1) eb = 1;
      x = {1'($urandom), ea[7:0], 23'($urandom)};
      y = {1'($urandom), eb[7:0], 23'($urandom)};
      if ($urandom_range(0, 1) == 1) drive(y, x, "R2/R3/R4/R12 random");
      else                           drive(x, y, "R2/R3/R4/R12 random");
    end
    idle(10);

    // R11: reset with pairs in flight
    drive(32'h3F800000, 32'h40000000, "R11 flushed");
    drive(32'h40400000, 32'h40000000, "R11 flushed");
    drive(32'h40800000, 32'h40000000, "R11 flushed");
    @(negedge clk_i);
    in_valid_i = 1'b0;
    rst_ni = 1'b0;
    sb.delete();
    check_quiet("R11 in reset");
    check_quiet("R11 in reset");
    @(negedge clk_i) rst_ni = 1'b1;
    for (int i = 0; i < 8; i++) check_quiet("R11 after reset");

    drive(32'h40000000, 32'h40000000, "R1 after reset");
    idle(10);
    finish_run();
  end
endmodule